// File: doc/BRIEF.md
# Sampling-Converter Command and Readout Slave on a Two-Wire Bus

This block is the digital front end of a 12-bit sampling converter that sits on a two-wire serial bus (I2C-compatible, 7-bit addressing). It runs in the system clock domain. SCL and SDA are brought in through two-flop synchronizers, and bus START, repeated START, STOP and clock edges are found from the synchronized levels. The block drives SDA as an open-drain line, shown here as an enable that pulls the wire low. It has no SCL output.

A master that writes to the block sends one configuration byte. The byte selects the input arrangement, the polarity mode and a sleep request for the analog core. The block converts only when told to. Any STOP that closes a transaction in which the block acknowledged its address starts a conversion. That STOP also hands the most recently written settings to the core. While the core is converting, the block refuses every address. When the core reports that it is done, the block stores the result. A later read returns the stored result at once, as two bytes: the 12 result bits MSB first, then four zero bits.

Top module: `adc_i2c_slave`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe`, `conv_start`, `cfg_o` and `sleep_o` are all low.
- R2: If the address in the first byte after a START equals parameter `SLV_ADDR` and no conversion is running, the block pulls SDA low for the ninth clock. If the address differs, the block leaves SDA released for that clock. It also acknowledges nothing and changes no setting until the next START.
- R3: From `conv_start` until `conv_done`, the block acknowledges no address and keeps `sda_oe` low.
- R4: A STOP that ends a transaction in which the block acknowledged its address (read or write) gives a one-cycle `conv_start` pulse. A STOP without that acknowledgement gives no pulse.
- R5: The block acknowledges a configuration byte written after its address. Byte bit 7 is the single-ended/differential select (to `cfg_o[2]`), bit 6 is the odd/sign select (to `cfg_o[1]`), bit 4 is the unipolar/bipolar select (to `cfg_o[0]`) and bit 2 is sleep (to `sleep_o`). Bits 5, 3, 1 and 0 have no effect.
- R6: `cfg_o` and `sleep_o` change only in the cycle of a `conv_start` pulse. At that point they take the values from the latest configuration byte written.
- R7: A `conv_done` pulse during a conversion stores `conv_result`. A read then returns result[11:4] in the first byte and {result[3:0], 4'b0000} in the second, MSB first. The data always comes from the latest completed conversion.
- R8: The block changes its SDA drive only while the synchronized SCL is low.
- R9: After a read, a repeated START followed by a write is accepted without an intervening STOP. The final STOP still starts exactly one conversion.
- R10: When the master does not acknowledge a read byte, the block releases SDA for the rest of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| conv_start | output | 1 | One-cycle conversion start strobe to the core |
| cfg_o | output | 3 | Applied settings: [2] single/diff, [1] odd/sign, [0] unipolar/bipolar |
| sleep_o | output | 1 | Applied sleep request to the core |
| conv_done | input | 1 | One-cycle pulse from the core when a conversion ends |
| conv_result | input | RES_W | Conversion result, valid with `conv_done` |

## Verification
The bench addresses the block right after a STOP has started a conversion. A design that ignored the busy window would acknowledge that address and could start a second conversion in the middle of the first.

It then writes a byte with every ignored bit set and follows with a read-only transaction. A decoder that took the wrong bit positions, or that let a rejected (wrong-address) transaction write its data, would show wrong settings at the next start.

It also checks the readout ordering and the zero padding on several result patterns. It reads across a repeated START into a write, and it ends reads with a master NACK. A design that lost the "addressed" state across the repeated START would miss a conversion. One that started a conversion after a rejected address would issue an unexpected start.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_SKIP
  } bus_st_e;

  // configuration byte bit positions
  localparam int CFG_SD_POS  = 7;
  localparam int CFG_OS_POS  = 6;
  localparam int CFG_UNI_POS = 4;
  localparam int CFG_SLP_POS = 2;

  typedef struct packed {
    logic sd;
    logic os;
    logic uni;
  } cfg_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import adc_i2c_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h48,
  parameter int         RES_W    = 12,
  parameter int         PAD_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             sda_rise,
  input  logic             sda_fall,
  input  logic             busy,
  input  logic [RES_W-1:0] result,
  output logic             sda_oe,
  output logic             conv_req,
  output logic             cfg_wr,
  output logic [7:0]       cfg_byte
);

  localparam int RD_W   = RES_W + PAD_W;
  localparam int NBYTES = RD_W / 8;
  localparam int BI_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

  bus_st_e          st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       shin_q, shin_n;
  logic [RD_W-1:0]  shout_q, shout_n;
  logic [BI_W-1:0]  bidx_q, bidx_n;
  logic             rw_q, rw_n;
  logic             adr_q, adr_n;
  logic             oe_q, oe_n;
  logic             mack_q, mack_n;
  logic             req_q, req_n;
  logic             wr_q, wr_n;
  logic             start_det, stop_det;
  logic [RD_W-1:0]  shifted;

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;
  assign shifted   = shout_q << 1;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    shin_n  = shin_q;
    shout_n = shout_q;
    bidx_n  = bidx_q;
    rw_n    = rw_q;
    adr_n   = adr_q;
    oe_n    = oe_q;
    mack_n  = mack_q;
    req_n   = 1'b0;
    wr_n    = 1'b0;
    if (stop_det) begin
      req_n = adr_q;
      adr_n = 1'b0;
      oe_n  = 1'b0;
      st_n  = ST_IDLE;
    end else if (start_det) begin
      oe_n  = 1'b0;
      cnt_n = '0;
      st_n  = ST_ADDR;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            shin_n = {shin_q[6:0], sda_lvl};
            cnt_n  = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (st_q == ST_WR) begin
              oe_n = 1'b1;
              wr_n = 1'b1;
              st_n = ST_WACK;
            end else if (shin_q[7:1] == SLV_ADDR && !busy) begin
              oe_n = 1'b1;
              rw_n = shin_q[0];
              st_n = ST_AACK;
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            adr_n = 1'b1;
            cnt_n = '0;
            if (rw_q) begin
              shout_n = {result, {PAD_W{1'b0}}};
              oe_n    = ~result[RES_W-1];
              bidx_n  = '0;
              st_n    = ST_RD;
            end else begin
              oe_n = 1'b0;
              st_n = ST_WR;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            shout_n = shifted;
            if (cnt_q == LAST_BIT) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              oe_n = ~shifted[RD_W-1];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q && (int'(bidx_q) < NBYTES - 1)) begin
              bidx_n = bidx_q + 1'b1;
              cnt_n  = '0;
              oe_n   = ~shout_q[RD_W-1];
              st_n   = ST_RD;
            end else begin
              oe_n = 1'b0;
              st_n = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      shin_q  <= '0;
      shout_q <= '0;
      bidx_q  <= '0;
      rw_q    <= 1'b0;
      adr_q   <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      shin_q  <= shin_n;
      shout_q <= shout_n;
      bidx_q  <= bidx_n;
      rw_q    <= rw_n;
      adr_q   <= adr_n;
      oe_q    <= oe_n;
      mack_q  <= mack_n;
      req_q   <= req_n;
      wr_q    <= wr_n;
    end
  end

  assign sda_oe   = oe_q;
  assign conv_req = req_q;
  assign cfg_wr   = wr_q;
  assign cfg_byte = shin_q;

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_i2c_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_req,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_byte,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             conv_start,
  output cfg_t             cfg_act,
  output logic             sleep_act,
  output logic             busy,
  output logic [RES_W-1:0] result
);

  cfg_t             pend_q, pend_n, act_q, act_n;
  logic             pslp_q, pslp_n, slp_q, slp_n;
  logic             busy_q, busy_n, go_q, go_n;
  logic [RES_W-1:0] res_q, res_n;
  logic             cfg_unused;

  assign cfg_unused = ^{cfg_byte[5], cfg_byte[3], cfg_byte[1:0]};

  always_comb begin
    pend_n = pend_q;
    pslp_n = pslp_q;
    act_n  = act_q;
    slp_n  = slp_q;
    busy_n = busy_q;
    res_n  = res_q;
    go_n   = 1'b0;
    if (cfg_wr) begin
      pend_n.sd  = cfg_byte[CFG_SD_POS];
      pend_n.os  = cfg_byte[CFG_OS_POS];
      pend_n.uni = cfg_byte[CFG_UNI_POS];
      pslp_n     = cfg_byte[CFG_SLP_POS];
    end
    if (conv_req && !busy_q) begin
      go_n   = 1'b1;
      busy_n = 1'b1;
      act_n  = pend_q;
      slp_n  = pslp_q;
    end else if (conv_done && busy_q) begin
      busy_n = 1'b0;
      res_n  = conv_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pslp_q <= 1'b0;
      act_q  <= '0;
      slp_q  <= 1'b0;
      busy_q <= 1'b0;
      res_q  <= '0;
      go_q   <= 1'b0;
    end else begin
      pend_q <= pend_n;
      pslp_q <= pslp_n;
      act_q  <= act_n;
      slp_q  <= slp_n;
      busy_q <= busy_n;
      res_q  <= res_n;
      go_q   <= go_n;
    end
  end

  assign conv_start = go_q;
  assign cfg_act    = act_q;
  assign sleep_act  = slp_q;
  assign busy       = busy_q;
  assign result     = res_q;

endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave
  import adc_i2c_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h48,
  parameter int         RES_W       = 12,
  parameter int         PAD_W       = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             conv_start,
  output logic [2:0]       cfg_o,
  output logic             sleep_o,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);

  logic [1:0]       rst_pipe;
  logic             rst_q;
  logic             scl_lvl, scl_rise, scl_fall;
  logic             sda_lvl, sda_rise, sda_fall;
  logic             busy, conv_req, cfg_wr;
  logic [7:0]       cfg_byte;
  logic [RES_W-1:0] result_q;
  cfg_t             cfg_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_q), .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_q), .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_slave_fsm #(.SLV_ADDR(SLV_ADDR), .RES_W(RES_W), .PAD_W(PAD_W)) u_fsm (
    .clk(clk), .rst_n(rst_q),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .busy(busy), .result(result_q),
    .sda_oe(sda_oe), .conv_req(conv_req), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte)
  );

  adc_conv_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_q),
    .conv_req(conv_req), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
    .conv_done(conv_done), .conv_result(conv_result),
    .conv_start(conv_start), .cfg_act(cfg_act), .sleep_act(sleep_o),
    .busy(busy), .result(result_q)
  );

  assign cfg_o = cfg_act;

endmodule

// File: rtl/adc_i2c_slave_chk.sv
module adc_i2c_slave_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             sda_oe,
  input logic             conv_start,
  input logic [2:0]       cfg_o,
  input logic             busy,
  input logic             conv_done,
  input logic [RES_W-1:0] conv_result,
  input logic [RES_W-1:0] result_q
);

  // R8
  sda_hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R3
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy) |=> (result_q == $past(conv_result)));

  // R6
  cfg_only_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> conv_start);

endmodule

bind adc_i2c_slave adc_i2c_slave_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
  .conv_start(conv_start), .cfg_o(cfg_o), .busy(busy),
  .conv_done(conv_done), .conv_result(conv_result), .result_q(result_q)
);

// File: tb/adc_i2c_slave_tb_top.sv
module adc_i2c_slave_tb_top;

  localparam logic [6:0] SLV = 7'h48;
  localparam int HALF     = 20;
  localparam int CORE_LAT = 1500;

  logic        clk = 1'b0;
  logic        rst_n, scl_m, sda_m, conv_done;
  logic [11:0] conv_result;
  logic        sda_oe, conv_start, sleep_o;
  logic [2:0]  cfg_o;
  logic        sda_line;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  adc_i2c_slave #(.SLV_ADDR(SLV)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .conv_start(conv_start), .cfg_o(cfg_o), .sleep_o(sleep_o),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed { logic [2:0] cfg; logic slp; } conv_exp_t;
  conv_exp_t exp_q[$];

  task automatic push_conv(logic [2:0] c, logic s);
    conv_exp_t e;
    e.cfg = c;
    e.slp = s;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: compares applied settings at each start
  initial begin
    conv_exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && conv_start) begin
        if (exp_q.size() == 0) chk("R4 unexpected conv_start", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk("R6/R5 cfg_o at start", int'(cfg_o), int'(e.cfg));
          chk("R5 sleep_o at start", int'(sleep_o), int'(e.slp));
        end
      end
    end
  end

  // core model
  logic [11:0] res_tab [8];
  int core_idx = 0;
  initial begin
    res_tab = '{12'hA5C, 12'h3F1, 12'h800, 12'h7FF, 12'h123, 12'h001, 12'hFFF, 12'h555};
    conv_done = 1'b0;
    conv_result = '0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        repeat (CORE_LAT) @(negedge clk);
        conv_result = res_tab[core_idx % 8];
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        core_idx++;
      end
    end
  end

  // R8: slave drive stays put while SCL is high
  initial begin
    logic prev_scl, prev_oe;
    prev_scl = 1'b1;
    prev_oe  = 1'b0;
    forever begin
      @(negedge clk);
      if (scl_m && prev_scl && (sda_oe != prev_oe)) viol++;
      prev_scl = scl_m;
      prev_oe  = sda_oe;
    end
  end

  task automatic bus_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; bus_wait(5);
    scl_m = 1'b1; bus_wait(HALF);
    sda_m = 1'b0; bus_wait(HALF);
    scl_m = 1'b0; bus_wait(5);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; bus_wait(5);
    scl_m = 1'b1; bus_wait(HALF);
    sda_m = 1'b1; bus_wait(HALF);
  endtask

  task automatic m_wr(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; bus_wait(HALF);
      scl_m = 1'b1; bus_wait(HALF);
      scl_m = 1'b0; bus_wait(5);
    end
    sda_m = 1'b1; bus_wait(HALF);
    scl_m = 1'b1; bus_wait(HALF / 2);
    ack = ~sda_line; bus_wait(HALF / 2);
    scl_m = 1'b0; bus_wait(5);
  endtask

  task automatic m_rd(logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bus_wait(HALF);
      scl_m = 1'b1; bus_wait(HALF / 2);
      b[i] = sda_line; bus_wait(HALF / 2);
      scl_m = 1'b0; bus_wait(5);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; bus_wait(HALF);
    scl_m = 1'b1; bus_wait(HALF);
    scl_m = 1'b0; bus_wait(5);
    sda_m = 1'b1;
  endtask

  task automatic read_check(logic [7:0] hi, logic [7:0] lo);
    logic ack;
    logic [7:0] b;
    m_start;
    m_wr({SLV, 1'b1}, ack); chk("R2 read address ack", int'(ack), 1);
    m_rd(1'b1, b);          chk("R7 first read byte", int'(b), int'(hi));
    m_rd(1'b0, b);          chk("R7 second read byte (zero pad)", int'(b), int'(lo));
    bus_wait(10);
    chk("R10 SDA released after master NACK", int'(sda_oe), 0);
  endtask

  initial begin
    logic ack;
    scl_m = 1'b1;
    sda_m = 1'b1;
    rst_n = 1'b0;
    bus_wait(5);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    chk("R1 conv_start in reset", int'(conv_start), 0);
    rst_n = 1'b1;
    bus_wait(5);
    chk("R1 cfg_o after reset", int'(cfg_o), 0);
    chk("R1 sleep_o after reset", int'(sleep_o), 0);

    // write config 1101_0100 -> cfg 111, sleep 1
    m_start;
    m_wr({SLV, 1'b0}, ack); chk("R2 write address ack", int'(ack), 1);
    m_wr(8'hD4, ack);       chk("R5 config byte ack", int'(ack), 1);
    push_conv(3'b111, 1'b1);
    m_stop;

    // busy window: address must be refused
    m_start;
    m_wr({SLV, 1'b0}, ack); chk("R3 address NACK while busy", int'(ack), 0);
    m_stop;
    bus_wait(CORE_LAT + 200);

    // read conv1, repeated START into write 0010_1011 (ignored bits only)
    read_check(8'hA5, 8'hC0);
    m_start;
    m_wr({SLV, 1'b0}, ack); chk("R9 write after repeated START ack", int'(ack), 1);
    m_wr(8'h2B, ack);       chk("R5 ignored-bit byte ack", int'(ack), 1);
    push_conv(3'b000, 1'b0);
    m_stop;
    bus_wait(CORE_LAT + 200);

    // read-only transaction, STOP starts a conversion with unchanged cfg
    read_check(8'h3F, 8'h10);
    push_conv(3'b000, 1'b0);
    m_stop;
    bus_wait(CORE_LAT + 200);

    // wrong address: NACK and following byte ignored, no conversion
    m_start;
    m_wr({7'h49, 1'b0}, ack); chk("R2 wrong address NACK", int'(ack), 0);
    m_wr(8'hFF, ack);         chk("R2 byte after wrong address NACK", int'(ack), 0);
    m_stop;
    bus_wait(200);
    chk("R4 no start after rejected address", exp_q.size(), 0);

    // read conv3; its STOP shows 0xFF was not taken
    read_check(8'h80, 8'h00);
    push_conv(3'b000, 1'b0);
    m_stop;
    bus_wait(CORE_LAT + 200);

    // odd/sign only -> cfg 010
    m_start;
    m_wr({SLV, 1'b0}, ack); chk("R2 write address ack", int'(ack), 1);
    m_wr(8'h40, ack);       chk("R5 odd/sign byte ack", int'(ack), 1);
    push_conv(3'b010, 1'b0);
    m_stop;
    bus_wait(CORE_LAT + 200);

    read_check(8'h12, 8'h30);
    push_conv(3'b010, 1'b0);
    m_stop;
    bus_wait(CORE_LAT + 200);

    chk("R4 every expected start seen", exp_q.size(), 0);
    chk("R8 SDA drive changes while SCL high", viol, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule